// File: doc/BRIEF.md
# Match-interrupt real-time counter

This peripheral keeps a running seconds count for software. A free-running counter advances on every rising edge of a slow tick clock that is separate from the bus clock. The bus side adds an offset to a synchronized copy of that counter to form the count that software reads. Software sets the count through a load register, which rewrites the offset. It also programs a match value. When the count reaches the match value, a sticky status bit is set. If the mask bit allows it, a level interrupt is raised and stays high until software clears it.

The block has three resets, each active high and synchronous to its own clock. The bus reset clears the mask, status and interrupt logic. The power-on reset also clears the match and offset registers and the synchronized count. The tick reset clears only the tick-domain counter. A soft bus reset therefore leaves the time, the match value and the offset unchanged. The tick clock must run at less than a third of the bus clock. The synchronizer depends on this ratio.

Register access follows a simple APB-style setup/access handshake. Registers sit at byte offsets 0x00 count, 0x04 match, 0x08 load, 0x0C mask, 0x10 raw status, 0x14 masked status and 0x18 clear. Addresses must be word aligned.

Top module: `rtc_match_timer`

## Requirements
- R1: Reading offset 0x00 returns the offset plus the number of tick-clock rising edges since tick reset, modulo 2^32. Each tick edge raises it by exactly one, and it wraps from 0xFFFFFFFF to 0.
- R2: A write to offset 0x08 makes the next read of 0x00 return the written value, and later ticks count on from that value. A read of 0x08 returns zero.
- R3: Offset 0x04 holds a 32-bit match value that reads back as written.
- R4: Bit 0 of offset 0x10 (raw status) is set on the bus cycle in which the count first becomes equal to the match value, whatever the mask. It then stays set until it is cleared, even after the count moves past the match.
- R5: Bit 0 of offset 0x0C is the mask. Only that bit is stored, and the other bits read as zero. The output irq and bit 0 of offset 0x14 equal raw status AND mask.
- R6: Writing 1 to bit 0 of offset 0x18 clears raw status. A write with bit 0 at zero has no effect. Raw status does not set again while the count stays equal to the match value. A read of 0x18 returns zero.
- R7: The bus reset clears the mask, raw status and irq. The count, match value and offset are unchanged by it.
- R8: The power-on reset clears the match value, the offset and the synchronized count, and irq is low. It does not touch the tick counter, so the count reads the tick total again from the next tick on.
- R9: The tick reset sets the tick counter to zero. After the next tick edge seen by the bus side, the count reads the offset plus zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high soft reset of the bus logic |
| por_rst | input | 1 | Synchronous active-high power-on reset (bus clock) |
| tick_clk | input | 1 | Slow tick clock that sets the counter resolution |
| tick_rst | input | 1 | Synchronous active-high reset of the tick-domain counter |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | CNT_W | Write data |
| prdata | output | CNT_W | Read data, valid in the access phase |
| irq | output | 1 | Level interrupt: raw status AND mask |

## Verification
Register writes take effect at the access-phase edge. Read data is registered at the setup-phase edge and sampled during the access phase. A tick edge shows up in the count within four bus edges. The raw status follows one edge later, and irq one edge after that. The bench holds each tick level for ten bus cycles and samples only at falling bus edges once that window has passed, so every expected count, status and interrupt value is compared after it is due and before the next tick edge.

// File: rtl/rtc_match_pkg.sv
package rtc_match_pkg;
  // word index of each register (byte offset / 4); the bus decodes these
  typedef enum logic [2:0] {
    SEL_COUNT  = 3'd0,
    SEL_MATCH  = 3'd1,
    SEL_LOAD   = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_RAW    = 3'd4,
    SEL_MASKED = 3'd5,
    SEL_CLEAR  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             tick_clk,
  input  logic             tick_rst,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge tick_clk) begin
    if (tick_rst) cnt_o <= '0;
    else          cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             tick_clk,
  input  logic [CNT_W-1:0] tick_cnt_i,
  output logic [CNT_W-1:0] sync_cnt_o
);
  // SYNC_N synchronizing flops plus one history flop for edge detection
  logic [SYNC_N:0] chain;
  logic            rise;
  logic            pend;

  assign rise = chain[SYNC_N-1] & ~chain[SYNC_N];

  always_ff @(posedge clk) begin
    if (por_rst) begin
      chain      <= '0;
      pend       <= 1'b0;
      sync_cnt_o <= '0;
    end else begin
      chain <= {chain[SYNC_N-1:0], tick_clk};
      pend  <= rise;
      // capture one cycle after the edge is seen; the tick count is settled
      if (pend) sync_cnt_o <= tick_cnt_i;
    end
  end

  AST_COPY_ONLY_AFTER_EDGE: assert property (@(posedge clk) disable iff (por_rst)
    (sync_cnt_o != $past(sync_cnt_o)) |-> $past(pend)); // R1
  AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (por_rst)
    pend |=> !pend); // R1
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_match_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic              por_rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  input  logic [CNT_W-1:0]  sync_cnt,
  output logic [CNT_W-1:0]  prdata,
  output logic              irq
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  logic             aligned;
  logic             wr_en;
  logic             rd_cap;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] offset_q;
  logic [CNT_W-1:0] count;
  logic             mask_q;
  logic             raw_q;
  logic             eq;
  logic             eq_q;
  logic             hit;
  logic             clr_hit;
  logic             soft_rst;
  logic [CNT_W-1:0] rdata_d;

  assign sel      = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr_en    = psel & penable & pwrite & aligned;
  assign rd_cap   = psel & ~penable & ~pwrite;
  assign count    = offset_q + sync_cnt;
  assign eq       = (count == match_q);
  assign hit      = eq & ~eq_q;
  assign clr_hit  = wr_en & (sel == SEL_W'(SEL_CLEAR)) & pwdata[0];
  assign soft_rst = bus_rst | por_rst;

  // match and offset survive a soft reset
  always_ff @(posedge clk) begin
    if (por_rst) begin
      match_q  <= '0;
      offset_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_W'(SEL_MATCH)) match_q  <= pwdata;
      if (sel == SEL_W'(SEL_LOAD))  offset_q <= pwdata - sync_cnt;
    end
  end

  // interrupt state; a new match wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (soft_rst) begin
      mask_q <= 1'b0;
      raw_q  <= 1'b0;
      eq_q   <= 1'b1;
      irq    <= 1'b0;
    end else begin
      eq_q <= eq;
      if (wr_en && sel == SEL_W'(SEL_MASK)) mask_q <= pwdata[0];
      if (hit)          raw_q <= 1'b1;
      else if (clr_hit) raw_q <= 1'b0;
      irq <= raw_q & mask_q;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (aligned) begin
      if (sel == SEL_W'(SEL_COUNT))  rdata_d = count;
      if (sel == SEL_W'(SEL_MATCH))  rdata_d = match_q;
      if (sel == SEL_W'(SEL_MASK))   rdata_d[0] = mask_q;
      if (sel == SEL_W'(SEL_RAW))    rdata_d[0] = raw_q;
      if (sel == SEL_W'(SEL_MASKED)) rdata_d[0] = raw_q & mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (soft_rst)    prdata <= '0;
    else if (rd_cap) prdata <= rdata_d;
  end

  AST_RAW_ON_MATCH: assert property (@(posedge clk) disable iff (soft_rst)
    hit |=> raw_q); // R4
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (soft_rst)
    (raw_q && !clr_hit) |=> raw_q); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (soft_rst)
    (clr_hit && !hit) |=> !raw_q); // R6
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (soft_rst)
    (!raw_q && !hit) |=> !raw_q); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (soft_rst)
    !mask_q |=> !irq); // R5
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (soft_rst)
    !raw_q |=> !irq); // R5
endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic              por_rst,
  input  logic              tick_clk,
  input  logic              tick_rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic              irq
);
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] sync_cnt;

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .tick_clk (tick_clk),
    .tick_rst (tick_rst),
    .cnt_o    (tick_cnt)
  );

  rtc_tick_sync #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_sync (
    .clk        (clk),
    .por_rst    (por_rst),
    .tick_clk   (tick_clk),
    .tick_cnt_i (tick_cnt),
    .sync_cnt_o (sync_cnt)
  );

  rtc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .bus_rst  (bus_rst),
    .por_rst  (por_rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .sync_cnt (sync_cnt),
    .prdata   (prdata),
    .irq      (irq)
  );
endmodule

// File: tb/rtc_match_timer_bench.sv
module rtc_match_timer_bench;
  localparam logic [4:0] A_COUNT = 5'h00, A_MATCH = 5'h04, A_LOAD = 5'h08,
                         A_MASK = 5'h0C, A_RAW = 5'h10, A_MIS = 5'h14, A_CLR = 5'h18;

  logic clk = 1'b0;
  logic bus_rst = 1'b1, por_rst = 1'b1, tick_rst = 1'b1, tick_clk = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int errors = 0, checks = 0;
  int unsigned tick_total = 0;
  logic [31:0] offs_m = '0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  rtc_match_timer u_rtc_match_timer (
    .clk(clk), .bus_rst(bus_rst), .por_rst(por_rst), .tick_clk(tick_clk),
    .tick_rst(tick_rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  function automatic logic [31:0] exp_count();
    return offs_m + tick_total;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic tick(input bit counted);
    @(negedge clk); tick_clk = 1;
    repeat (10) @(negedge clk);
    tick_clk = 0;
    repeat (10) @(negedge clk);
    if (counted) tick_total++;
  endtask

  task automatic load(input logic [31:0] v);
    bus_wr(A_LOAD, v);
    offs_m = v - tick_total;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    tick(1'b0);
    bus_rst = 0; por_rst = 0; tick_rst = 0;
    repeat (5) @(negedge clk);

    // reset state
    chk("R7 irq after reset", {31'b0, irq}, 32'd0);
    bus_rd(A_COUNT, rd); chk("R1 count after reset", rd, 32'd0);
    bus_rd(A_MATCH, rd); chk("R8 match after reset", rd, 32'd0);
    bus_rd(A_RAW, rd);   chk("R4 raw after reset", rd, 32'd0);

    // R1 plain counting
    repeat (3) tick(1'b1);
    bus_rd(A_COUNT, rd); chk("R1 three ticks", rd, exp_count());

    // R2 load and read back
    load(32'h1234_5678);
    bus_rd(A_COUNT, rd); chk("R2 load immediate", rd, 32'h1234_5678);
    bus_rd(A_LOAD, rd);  chk("R2 load reads zero", rd, 32'd0);
    tick(1'b1);
    bus_rd(A_COUNT, rd); chk("R2 count on from load", rd, 32'h1234_5679);

    // R1 wrap
    load(32'hFFFF_FFFF);
    tick(1'b1);
    bus_rd(A_COUNT, rd); chk("R1 wrap", rd, 32'd0);

    // R3 match readback
    bus_wr(A_MATCH, 32'hA5A5_0003);
    bus_rd(A_MATCH, rd); chk("R3 match readback", rd, 32'hA5A5_0003);

    // R4 raw with mask off
    bus_wr(A_MASK, 32'd0);
    load(32'd100);
    bus_wr(A_MATCH, 32'd102);
    bus_wr(A_CLR, 32'd1);
    tick(1'b1);
    bus_rd(A_RAW, rd); chk("R4 raw before match", rd, 32'd0);
    tick(1'b1);
    bus_rd(A_RAW, rd); chk("R4 raw on match unmasked", rd, 32'd1);
    bus_rd(A_MIS, rd); chk("R5 masked status off", rd, 32'd0);
    chk("R5 irq masked off", {31'b0, irq}, 32'd0);
    tick(1'b1);
    bus_rd(A_RAW, rd); chk("R4 raw sticky past match", rd, 32'd1);

    // R5 enabling mask
    bus_wr(A_MASK, 32'hFFFF_FFFF);
    bus_rd(A_MASK, rd); chk("R5 mask upper bits zero", rd, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 irq after unmask", {31'b0, irq}, 32'd1);
    bus_rd(A_MIS, rd); chk("R5 masked status on", rd, 32'd1);

    // R6 clear behaviour
    bus_wr(A_CLR, 32'hFFFF_FFFE);
    bus_rd(A_RAW, rd); chk("R6 clear with bit0 zero ignored", rd, 32'd1);
    bus_rd(A_CLR, rd); chk("R6 clear reads zero", rd, 32'd0);
    bus_wr(A_CLR, 32'd1);
    repeat (3) @(negedge clk);
    bus_rd(A_RAW, rd); chk("R6 raw cleared", rd, 32'd0);
    chk("R6 irq cleared", {31'b0, irq}, 32'd0);
    load(32'd200);
    bus_wr(A_MATCH, 32'd200);
    repeat (3) @(negedge clk);
    bus_rd(A_RAW, rd); chk("R4 raw on match write", rd, 32'd1);
    bus_wr(A_CLR, 32'd1);
    repeat (6) @(negedge clk);
    bus_rd(A_RAW, rd); chk("R6 no refire while equal", rd, 32'd0);

    // R7 soft reset
    load(32'd300);
    bus_wr(A_MATCH, 32'd301);
    bus_wr(A_CLR, 32'd1);
    tick(1'b1);
    chk("R5 irq on match", {31'b0, irq}, 32'd1);
    @(negedge clk); bus_rst = 1;
    repeat (2) @(negedge clk); bus_rst = 0;
    repeat (2) @(negedge clk);
    chk("R7 irq low after soft reset", {31'b0, irq}, 32'd0);
    bus_rd(A_RAW, rd);   chk("R7 raw cleared", rd, 32'd0);
    bus_rd(A_MASK, rd);  chk("R7 mask cleared", rd, 32'd0);
    bus_rd(A_COUNT, rd); chk("R7 count kept", rd, 32'd301);
    bus_rd(A_MATCH, rd); chk("R7 match kept", rd, 32'd301);

    // R8 power-on reset
    @(negedge clk); por_rst = 1;
    repeat (2) @(negedge clk); por_rst = 0;
    offs_m = '0;
    repeat (2) @(negedge clk);
    chk("R8 irq low after power-on", {31'b0, irq}, 32'd0);
    bus_rd(A_MATCH, rd); chk("R8 match cleared", rd, 32'd0);
    tick(1'b1);
    bus_rd(A_COUNT, rd); chk("R8 tick counter untouched", rd, exp_count());

    // R9 tick reset
    @(negedge clk); tick_rst = 1;
    tick(1'b0);
    tick_rst = 0; tick_total = 0;
    bus_rd(A_COUNT, rd); chk("R9 tick reset count", rd, 32'd0);
    tick(1'b1);
    bus_rd(A_COUNT, rd); chk("R9 counts after tick reset", rd, 32'd1);

    // random match scenarios
    for (int i = 0; i < 24; i++) begin
      logic [31:0] v;
      int unsigned k;
      logic m;
      v = $urandom;
      k = 1 + ($urandom % 4);
      m = 1'($urandom % 2);
      bus_wr(A_MASK, {31'b0, m});
      load(v);
      bus_wr(A_MATCH, v + k);
      bus_wr(A_CLR, 32'd1);
      for (int t = 0; t < int'(k) - 1; t++) tick(1'b1);
      bus_rd(A_RAW, rd); chk("R4 random before match", rd, 32'd0);
      tick(1'b1);
      bus_rd(A_COUNT, rd); chk("R1 random count", rd, exp_count());
      bus_rd(A_RAW, rd);   chk("R4 random raw", rd, 32'd1);
      chk("R5 random irq", {31'b0, irq}, {31'b0, m});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule